// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a memory-mapped periodic timer with a 32-bit register port. Software programs a reload value, selects where the count tick comes from, and enables the timer. From then on the counter steps down once per selected tick. Each time the count arrives at zero, a sticky count flag is raised and, when interrupts are allowed, a one-cycle interrupt pulse is sent towards the interrupt controller. The counter is then refilled from the reload value, so the period is reload+1 ticks.

The tick source is chosen by one control bit. One setting counts every core clock cycle. The other counts only on cycles where an external reference tick-enable input is high. Three behaviours are easy to miss. Reading status clears the count flag. Writing the current-value register with any data restarts the count. A reload value of zero makes the timer switch itself off at the point where it would otherwise refill.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status, reload and current-value registers all read as zero, and irq is low.
- R2: Control/status is at offset 0x0. A write updates only bit 0 (enable), bit 1 (interrupt enable) and bit 2 (source select). Bit 16 is the count flag, which writes cannot change. Every other bit reads as zero.
- R3: A write that changes enable from 0 to 1 arms a load. On the next selected tick the counter takes the reload value, and each later selected tick lowers it by one. No counting step happens in a cycle that writes control/status or current value.
- R4: With source select at 1 the counter steps on every clock cycle. With source select at 0 it steps only on cycles where ref_tick is high.
- R5: When a counting step takes the count from 1 to 0, the count flag is set. If interrupt enable is 1, irq is high for exactly the next clock cycle.
- R6: On the first selected tick after the count reaches 0, the counter reloads, so the period is reload+1 ticks. If the reload value is 0 at that point, enable is cleared instead.
- R7: Reading control/status returns the flag as it stood before the read, then clears the flag. If an expiry falls in the same cycle as the read, the flag stays set.
- R8: Any write to offset 0x8, whatever the data, copies the reload value into the counter, clears the count flag and cancels any pending armed load.
- R9: Offset 0x8 reads as the counter value while enabled and as zero while disabled.
- R10: Offset 0xC always reads 10000. Reads of other offsets outside 0x0, 0x4, 0x8 and 0xC return zero, and writes to them change no register.
- R11: Offset 0x4 holds the reload value, which can be written and read back in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | External reference tick enable, used when source select is 0 |
| bus_wr | input | 1 | Write strobe for one 32-bit register access |
| bus_rd | input | 1 | Read strobe; has a side effect on the count flag |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high, zero otherwise |
| irq | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
The hardest cases to reach are collisions between a bus access and a counter expiry in the same cycle. Examples are a status read that meets a fresh flag, a current-value write that cancels an expiry, and a reload of zero that takes effect in the cycle the timer would refill. These are reached by keeping reload values small (0 to 7) during a long random run, so expiries come every few cycles while reads and writes land at random offsets and the reference tick toggles randomly. A reference model in the bench follows every cycle. Directed sequences cover the period, the held count under the external tick, the self-stop and the register masks.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
    localparam int OFF_CTRL   = 'h0;
    localparam int OFF_RELOAD = 'h4;
    localparam int OFF_CUR    = 'h8;
    localparam int OFF_CAL    = 'hC;
    localparam int BIT_EN     = 0;
    localparam int BIT_IE     = 1;
    localparam int BIT_SRC    = 2;
    localparam int BIT_FLAG   = 16;
endpackage

// File: rtl/tick_timer_src.sv
`timescale 1ns/1ps
module tick_timer_src (
    input  logic src_core,
    input  logic ref_tick,
    output logic tick
);
    always_comb begin
        tick = src_core ? 1'b1 : ref_tick;
    end
endmodule

// File: rtl/tick_timer_core.sv
`timescale 1ns/1ps
module tick_timer_core #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              en_q,
    output logic              ie_q,
    output logic              src_q,
    output logic              flag_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              irq
);
    import tick_timer_pkg::*;

    typedef struct packed {
        logic             en;
        logic             ie;
        logic             src;
        logic             flag;
        logic             pend;
        logic             irq;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] count;
    } state_t;

    state_t st_q, st_d;
    logic   wr_ctrl, wr_rel, wr_cur, rd_ctrl, expire;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
        wr_rel  = bus_wr && (bus_addr == ADDR_W'(OFF_RELOAD));
        wr_cur  = bus_wr && (bus_addr == ADDR_W'(OFF_CUR));
        rd_ctrl = bus_rd && (bus_addr == ADDR_W'(OFF_CTRL));
        expire  = 1'b0;
        st_d     = st_q;
        st_d.irq = 1'b0;

        // counting step, skipped when software rewrites control or count
        if (st_q.en && tick && !wr_ctrl && !wr_cur) begin
            if (st_q.pend) begin
                st_d.count = st_q.reload;
                st_d.pend  = 1'b0;
            end else if (st_q.count == '0) begin
                if (st_q.reload == '0) begin
                    st_d.en = 1'b0;
                end else begin
                    st_d.count = st_q.reload;
                end
            end else begin
                st_d.count = st_q.count - 1'b1;
                expire     = (st_q.count == CNT_W'(1));
            end
        end

        if (rd_ctrl) begin
            st_d.flag = 1'b0;
        end
        if (expire) begin
            st_d.flag = 1'b1;
            st_d.irq  = st_q.ie;
        end

        if (wr_ctrl) begin
            st_d.en   = bus_wdata[BIT_EN];
            st_d.ie   = bus_wdata[BIT_IE];
            st_d.src  = bus_wdata[BIT_SRC];
            st_d.pend = bus_wdata[BIT_EN] && (st_q.pend || !st_q.en);
        end
        if (wr_rel) begin
            st_d.reload = bus_wdata[CNT_W-1:0];
        end
        if (wr_cur) begin
            st_d.count = st_q.reload;
            st_d.flag  = 1'b0;
            st_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q     = st_q.en;
    assign ie_q     = st_q.ie;
    assign src_q    = st_q.src;
    assign flag_q   = st_q.flag;
    assign reload_q = st_q.reload;
    assign count_q  = st_q.count;
    assign irq      = st_q.irq;
endmodule

// File: rtl/tick_timer_rdmux.sv
`timescale 1ns/1ps
module tick_timer_rdmux #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 32,
    parameter int CAL_VALUE = 10000
) (
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              en_q,
    input  logic              ie_q,
    input  logic              src_q,
    input  logic              flag_q,
    input  logic [CNT_W-1:0]  reload_q,
    input  logic [CNT_W-1:0]  count_q,
    output logic [DATA_W-1:0] bus_rdata
);
    import tick_timer_pkg::*;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_W'(OFF_CTRL): begin
                    bus_rdata[BIT_EN]   = en_q;
                    bus_rdata[BIT_IE]   = ie_q;
                    bus_rdata[BIT_SRC]  = src_q;
                    bus_rdata[BIT_FLAG] = flag_q;
                end
                ADDR_W'(OFF_RELOAD): bus_rdata[CNT_W-1:0] = reload_q;
                ADDR_W'(OFF_CUR):    bus_rdata[CNT_W-1:0] = en_q ? count_q : '0;
                ADDR_W'(OFF_CAL):    bus_rdata = DATA_W'(CAL_VALUE);
                default:             bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer #(
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 32,
    parameter int CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int DATA_W = 32;

    logic             tick;
    logic             en_q, ie_q, src_q, flag_q;
    logic [CNT_W-1:0] reload_q, count_q;

    tick_timer_src u_src (
        .src_core (src_q),
        .ref_tick (ref_tick),
        .tick     (tick)
    );

    tick_timer_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .en_q      (en_q),
        .ie_q      (ie_q),
        .src_q     (src_q),
        .flag_q    (flag_q),
        .reload_q  (reload_q),
        .count_q   (count_q),
        .irq       (irq)
    );

    tick_timer_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                       .CAL_VALUE(CAL_VALUE)) u_rdmux (
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .en_q      (en_q),
        .ie_q      (ie_q),
        .src_q     (src_q),
        .flag_q    (flag_q),
        .reload_q  (reload_q),
        .count_q   (count_q),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: rtl/tick_timer_chk.sv
`timescale 1ns/1ps
module tick_timer_chk #(
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 32,
    parameter int CAL_VALUE = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              en_q,
    input logic              ie_q,
    input logic              flag_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  count_q
);
    p_irq_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);
    p_irq_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ie_q));
    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(0)) |-> ((bus_rdata & ~32'h0001_0007) == 32'h0));
    p_cal_const_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(12)) |-> (bus_rdata == 32'(CAL_VALUE)));
    p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(8) && !en_q) |-> (bus_rdata == 32'h0));
    p_cur_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8)) |=> (!flag_q && count_q == $past(reload_q)));
    p_self_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(en_q) && !$past(bus_wr)) |-> ($past(reload_q) == '0));
endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .en_q      (en_q),
    .ie_q      (ie_q),
    .flag_q    (flag_q),
    .reload_q  (reload_q),
    .count_q   (count_q)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    logic        m_en = 0, m_ie = 0, m_src = 0, m_flag = 0, m_pend = 0, m_irq = 0;
    logic [31:0] m_rel = 0, m_cnt = 0;

    always #10 clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'h0: return {15'b0, m_flag, 13'b0, m_src, m_ie, m_en};
            4'h4: return m_rel;
            4'h8: return m_en ? m_cnt : 32'h0;
            4'hC: return 32'd10000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [3:0] a);
        case (a)
            4'h0: return "R7 status read";
            4'h4: return "R11 reload read";
            4'h8: return "R9 current read";
            4'hC: return "R10 calibration read";
            default: return "R10 unmapped read";
        endcase
    endfunction

    task automatic model_step(input logic wr, input logic rd, input logic [3:0] a,
                              input logic [31:0] wd, input logic rt);
        logic tk, wctl, wcur, exp_evt;
        logic n_en, n_pend, n_flag;
        logic [31:0] n_cnt;
        tk = m_src ? 1'b1 : rt;
        wctl = wr && a == 4'h0;
        wcur = wr && a == 4'h8;
        exp_evt = 0;
        n_en = m_en; n_pend = m_pend; n_flag = m_flag; n_cnt = m_cnt;
        if (m_en && tk && !wctl && !wcur) begin
            if (m_pend) begin n_cnt = m_rel; n_pend = 0; end
            else if (m_cnt == 0) begin
                if (m_rel == 0) n_en = 0; else n_cnt = m_rel;
            end else begin
                n_cnt = m_cnt - 1;
                exp_evt = (m_cnt == 1);
            end
        end
        if (rd && a == 4'h0) n_flag = 0;
        m_irq = exp_evt && m_ie;
        if (exp_evt) n_flag = 1;
        if (wctl) begin
            n_pend = wd[0] && (m_pend || !m_en);
            n_en = wd[0]; m_ie = wd[1]; m_src = wd[2];
        end
        if (wcur) begin n_cnt = m_rel; n_flag = 0; n_pend = 0; end
        if (wr && a == 4'h4) m_rel = wd;
        m_en = n_en; m_pend = n_pend; m_flag = n_flag; m_cnt = n_cnt;
    endtask

    task automatic do_cycle(input logic wr, input logic rd, input logic [3:0] a,
                            input logic [31:0] wd, input logic rt, output logic [31:0] rv);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; ref_tick = rt;
        #5;
        rv = bus_rdata;
        if (rd) check(bus_rdata == exp_read(a), tag_for(a), bus_rdata, exp_read(a));
        @(posedge clk);
        model_step(wr, rd, a, wd, rt);
        #1;
        check(irq == m_irq, "R5 irq pulse", {31'b0, irq}, {31'b0, m_irq});
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] rv;
        do_cycle(1, 0, a, d, 0, rv);
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] rv);
        do_cycle(0, 1, a, 0, 0, rv);
    endtask

    task automatic idle(input int n, input logic rt);
        logic [31:0] rv;
        for (int i = 0; i < n; i++) do_cycle(0, 0, 4'h0, 0, rt, rv);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        int last_irq, gap_ok, seen;
        repeat (4) @(negedge clk);
        check(irq == 1'b0, "R1 irq low in reset", {31'b0, irq}, 0);
        rst_n = 1'b1;

        rd_reg(4'h0, v); check(v == 0, "R1 reset control", v, 0);
        rd_reg(4'h4, v); check(v == 0, "R1 reset reload", v, 0);
        rd_reg(4'h8, v); check(v == 0, "R1 reset current", v, 0);

        // R11 full-width reload, R10 calibration and unmapped
        wr_reg(4'h4, 32'hA5C3_9E71);
        rd_reg(4'h4, v); check(v == 32'hA5C3_9E71, "R11 reload readback", v, 32'hA5C3_9E71);
        rd_reg(4'hC, v); check(v == 32'd10000, "R10 calibration", v, 32'd10000);
        wr_reg(4'h6, 32'hFFFF_FFFF);
        rd_reg(4'h6, v); check(v == 0, "R10 unmapped read zero", v, 0);
        rd_reg(4'h4, v); check(v == 32'hA5C3_9E71, "R10 unmapped write ignored", v, 32'hA5C3_9E71);
        rd_reg(4'h0, v); check(v == 0, "R10 unmapped write ignored ctrl", v, 0);

        // R2 mask on control write, R6 period of reload+1
        wr_reg(4'h4, 32'd3);
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_reg(4'h0, v); check(v == 32'h7, "R2 control write mask", v, 32'h7);
        last_irq = -1; gap_ok = 1; seen = 0;
        for (int i = 0; i < 14; i++) begin
            idle(1, 0);
            if (irq) begin
                if (last_irq >= 0 && i - last_irq != 4) gap_ok = 0;
                last_irq = i; seen++;
            end
        end
        check(gap_ok == 1 && seen >= 3, "R6 period reload+1", seen, 3);

        // R7 read clears flag
        wr_reg(4'h0, 32'h5);
        idle(5, 0);
        rd_reg(4'h0, v); check(v[16] == 1'b1, "R7 flag seen", v, 32'h1_0005);
        wr_reg(4'h0, 32'h0);
        rd_reg(4'h0, v); check(v[16] == 1'b0, "R7 flag cleared by read", v, 0);

        // R3/R4 external tick source
        wr_reg(4'h4, 32'd20);
        wr_reg(4'h0, 32'h1);
        idle(1, 1);
        rd_reg(4'h8, v); check(v == 32'd20, "R3 load on first tick", v, 32'd20);
        idle(10, 0);
        rd_reg(4'h8, v2); check(v2 == 32'd20, "R4 held without ref tick", v2, 32'd20);
        idle(3, 1);
        rd_reg(4'h8, v); check(v == 32'd17, "R4 steps on ref tick", v, 32'd17);

        // R8 current-value write restarts
        wr_reg(4'h0, 32'h5);
        idle(19, 0);
        wr_reg(4'h8, 32'hDEAD_BEEF);
        rd_reg(4'h0, v); check(v[16] == 1'b0, "R8 flag cleared by current write", v, 0);
        rd_reg(4'h8, v); check(v == 32'd19, "R8 restart from reload", v, 32'd19);

        // R6 reload zero stops the timer
        wr_reg(4'h4, 32'd0);
        idle(25, 0);
        rd_reg(4'h0, v); check(v[0] == 1'b0, "R6 self stop on zero reload", v, 0);
        rd_reg(4'h8, v); check(v == 0, "R9 current zero when disabled", v, 0);

        // random phase
        void'($urandom(32'd1357));
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] r, d;
            logic [3:0] a;
            logic wr, rd;
            r = $urandom;
            wr = (r[3:0] == 4'd0);
            rd = !wr && (r[3:0] < 4'd4);
            a = {r[7:6], 2'b00};
            if (r[8] && r[9] && r[10]) a = r[15:12];
            d = $urandom;
            if (a == 4'h4) d = {29'b0, d[2:0]};
            do_cycle(wr, rd, a, d, r[16], v);
        end
        finish_run();
    end
endmodule